// File: doc/BRIEF.md
# Multicycle Integer Processor Core

This block is a small processor core that runs one instruction at a time through a sequence of states. It fetches 32-bit instruction words over a request/response instruction port and decodes them into a reduced integer instruction set. It executes register arithmetic, a signed comparison, a conditional branch, absolute jumps, a jump that saves a return address, word loads and stores over a separate data port, a cache-control operation and a halt. A 32-entry register file holds the operands, and register 0 is hard-wired to zero.

The instruction port is driven by the program counter. The core holds `imem_req` and the address steady until the memory answers with `imem_rvalid`. Loads hold `dmem_req` in the same way until `dmem_rvalid` arrives. A store is a single-cycle write request. The cache-control instruction drives two outputs toward an external cache: a level enable and a one-cycle flush strobe. After a halt instruction the core parks in a terminal state, raises `halted` and stops all memory traffic until the next reset.

Top module: `mini_core`

## Requirements
- R1: While `rst_n` is low and after its release, PC and all registers are zero, and `halted`, `cache_en`, `cache_flush` and `dmem_req` are low. The first fetch after release requests address 0.
- R2: Instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift [10:6] (must be zero), function [5:0], immediate [15:0] (sign-extended) and target [25:0]. Opcode 0x00 with function 0x20 writes rs+rt to rd, and function 0x22 writes rs−rt to rd. Opcode 0x08 writes rs+immediate to rt. All arithmetic wraps modulo 2^32.
- R3: Opcode 0x00 with function 0x2A writes 1 to rd when rs is less than rt as signed values, and 0 otherwise.
- R4: Opcode 0x05 branches to (PC+4)+immediate×4 when rs and rt differ; otherwise it continues at PC+4. Fetch addresses are always word aligned.
- R5: Opcode 0x02 sets PC to target×4. Opcode 0x03 writes PC+4 into register 7, then sets PC to target×4.
- R6: Opcode 0x23 loads the word at rs+immediate into rt, holding the request and address until `dmem_rvalid`. Opcode 0x2B writes rt to rs+immediate with a request that lasts exactly one cycle.
- R7: Opcode 0x2F reads a code from the immediate. Code 0 clears `cache_en`, code 1 sets it, code 2 pulses `cache_flush` for one cycle without changing `cache_en`, and any other code has no effect.
- R8: Opcode 0x3F makes `halted` rise. It stays high until reset, and no instruction or data request is issued while it is high.
- R9: Register 0 reads as zero, and writes to it are discarded.
- R10: An undefined opcode, or opcode 0x00 with an unknown function or a nonzero shift field, changes no register and no output other than advancing to PC+4.
- R11: A fetch holds `imem_req` and its address until `imem_rvalid`, and the instruction and data requests are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_req | output | 1 | Instruction fetch request |
| imem_addr | output | 32 | Fetch byte address (the PC) |
| imem_rvalid | input | 1 | Instruction word is valid |
| imem_rdata | input | 32 | Instruction word |
| dmem_req | output | 1 | Data access request |
| dmem_we | output | 1 | Data access is a write |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rvalid | input | 1 | Load data is valid |
| dmem_rdata | input | 32 | Load data |
| cache_en | output | 1 | Cache enable level |
| cache_flush | output | 1 | One-cycle cache flush strobe |
| halted | output | 1 | Core has executed a halt |

## Verification
The bound checker watches the port protocols on every cycle. It checks that a fetch or a load holds its request and address until answered, that a store request lasts one cycle, and that the two ports are never busy together. It also checks that fetch addresses are aligned, that the flush strobe lasts one cycle with the enable level steady, that halt is sticky and silent, and that register 0 always reads zero. Arithmetic results, signed comparison, branch direction, jump and link targets, skipped instructions, ignored cache codes and undefined encodings only show up in what the program stores. The bench runs one program covering all of these and compares every store address and value.

// File: rtl/mcore_pkg.sv
`timescale 1ns/1ps
package mcore_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_CACHE = 6'h2F;
  localparam logic [5:0] OP_HALT  = 6'h3F;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [XLEN-1:0] CC_OFF   = 32'd0;
  localparam logic [XLEN-1:0] CC_ON    = 32'd1;
  localparam logic [XLEN-1:0] CC_FLUSH = 32'd2;

  typedef enum logic [3:0] {
    K_NOP, K_ADD, K_SUB, K_SLT, K_ADDI, K_BNE, K_J, K_JAL,
    K_LW, K_SW, K_CACHE, K_HALT
  } kind_e;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB, S_HALT
  } state_e;

  typedef struct packed {
    kind_e             kind;
    logic [REG_AW-1:0] rs;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] wr;
    logic              writes;
    logic [XLEN-1:0]   imm;
    logic [25:0]       target;
  } dec_t;

  function automatic logic [XLEN-1:0] f_sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_slt(input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b);
    return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
  endfunction

  function automatic logic [XLEN-1:0] f_branch(input logic [XLEN-1:0] pc,
                                               input logic [XLEN-1:0] off);
    return pc + 32'd4 + {off[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] f_jump(input logic [25:0] tgt);
    return {4'b0000, tgt, 2'b00};
  endfunction

endpackage

// File: rtl/mcore_regfile.sv
`timescale 1ns/1ps
module mcore_regfile #(
  parameter int AW = 5,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  localparam int NREG = 1 << AW;

  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && wa == AW'(g))
        regs[g] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

endmodule

// File: rtl/mcore_decode.sv
`timescale 1ns/1ps
module mcore_decode
  import mcore_pkg::*;
#(
  parameter int LINK_REG = 7
) (
  input  logic [31:0] ir,
  output dec_t        dec
);
  logic [5:0] op;
  logic [5:0] fn;

  assign op = ir[31:26];
  assign fn = ir[5:0];

  always_comb begin
    dec        = '0;
    dec.kind   = K_NOP;
    dec.rs     = ir[25:21];
    dec.rt     = ir[20:16];
    dec.imm    = f_sext16(ir[15:0]);
    dec.target = ir[25:0];
    case (op)
      OP_RTYPE: begin
        dec.wr = ir[15:11];
        if (ir[10:6] == 5'd0) begin
          case (fn)
            FN_ADD:  dec.kind = K_ADD;
            FN_SUB:  dec.kind = K_SUB;
            FN_SLT:  dec.kind = K_SLT;
            default: dec.kind = K_NOP;
          endcase
        end
        dec.writes = (dec.kind != K_NOP);
      end
      OP_ADDI: begin
        dec.kind   = K_ADDI;
        dec.wr     = ir[20:16];
        dec.writes = 1'b1;
      end
      OP_LW: begin
        dec.kind   = K_LW;
        dec.wr     = ir[20:16];
        dec.writes = 1'b1;
      end
      OP_SW:    dec.kind = K_SW;
      OP_BNE:   dec.kind = K_BNE;
      OP_J:     dec.kind = K_J;
      OP_JAL: begin
        dec.kind   = K_JAL;
        dec.wr     = REG_AW'(LINK_REG);
        dec.writes = 1'b1;
      end
      OP_CACHE: dec.kind = K_CACHE;
      OP_HALT:  dec.kind = K_HALT;
      default:  dec.kind = K_NOP;
    endcase
  end

endmodule

// File: rtl/mcore_alu.sv
`timescale 1ns/1ps
module mcore_alu
  import mcore_pkg::*;
(
  input  kind_e             kind,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic [XLEN-1:0]   imm,
  input  logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   y
);
  always_comb begin
    case (kind)
      K_ADD:              y = opa + opb;
      K_SUB:              y = opa - opb;
      K_SLT:              y = f_slt(opa, opb);
      K_ADDI, K_LW, K_SW: y = opa + imm;
      K_JAL:              y = pc + 32'd4;
      default:            y = '0;
    endcase
  end
endmodule

// File: rtl/mcore_nextpc.sv
`timescale 1ns/1ps
module mcore_nextpc
  import mcore_pkg::*;
(
  input  kind_e           kind,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] imm,
  input  logic [25:0]     target,
  output logic [XLEN-1:0] npc,
  output logic            redirect
);
  always_comb begin
    redirect = 1'b0;
    npc      = pc + 32'd4;
    case (kind)
      K_BNE: if (opa != opb) begin
        redirect = 1'b1;
        npc      = f_branch(pc, imm);
      end
      K_J, K_JAL: begin
        redirect = 1'b1;
        npc      = f_jump(target);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mini_core.sv
`timescale 1ns/1ps
module mini_core
  import mcore_pkg::*;
#(
  parameter int LINK_REG = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        imem_req,
  output logic [31:0] imem_addr,
  input  logic        imem_rvalid,
  input  logic [31:0] imem_rdata,
  output logic        dmem_req,
  output logic        dmem_we,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  input  logic        dmem_rvalid,
  input  logic [31:0] dmem_rdata,
  output logic        cache_en,
  output logic        cache_flush,
  output logic        halted
);
  state_e            state;
  logic [XLEN-1:0]   pc;
  logic [31:0]       ir;
  logic [XLEN-1:0]   opa, opb, res;
  logic              en_q, flush_q;
  dec_t              dec;

  logic [XLEN-1:0]   alu_y, npc;
  logic              ev_redirect;
  logic [REG_AW-1:0] rd_addr_a;
  logic [XLEN-1:0]   rd_a, rd_b;
  logic              ev_rf_we;
  logic [REG_AW-1:0] ev_rf_waddr;

  mcore_decode #(.LINK_REG(LINK_REG)) i_dec (
    .ir  (ir),
    .dec (dec)
  );

  assign rd_addr_a = dec.rs;

  mcore_regfile #(.AW(REG_AW), .W(XLEN)) i_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .ra_a (rd_addr_a),
    .rd_a (rd_a),
    .ra_b (dec.rt),
    .rd_b (rd_b),
    .we   (ev_rf_we),
    .wa   (ev_rf_waddr),
    .wd   (res)
  );

  mcore_alu i_alu (
    .kind(dec.kind),
    .opa (opa),
    .opb (opb),
    .imm (dec.imm),
    .pc  (pc),
    .y   (alu_y)
  );

  mcore_nextpc i_npc (
    .kind    (dec.kind),
    .pc      (pc),
    .opa     (opa),
    .opb     (opb),
    .imm     (dec.imm),
    .target  (dec.target),
    .npc     (npc),
    .redirect(ev_redirect)
  );

  assign ev_rf_we    = (state == S_WB) && dec.writes;
  assign ev_rf_waddr = dec.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_FETCH;
      pc      <= '0;
      ir      <= '0;
      opa     <= '0;
      opb     <= '0;
      res     <= '0;
      en_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= 1'b0;
      case (state)
        S_FETCH: if (imem_rvalid) begin
          ir    <= imem_rdata;
          state <= S_DECODE;
        end
        S_DECODE: begin
          opa   <= rd_a;
          opb   <= rd_b;
          state <= S_EXEC;
        end
        S_EXEC: begin
          pc  <= npc;
          res <= alu_y;
          case (dec.kind)
            K_ADD, K_SUB, K_SLT, K_ADDI, K_JAL: state <= S_WB;
            K_LW, K_SW:                          state <= S_MEM;
            K_HALT:                              state <= S_HALT;
            K_CACHE: begin
              if (dec.imm == CC_OFF)   en_q    <= 1'b0;
              if (dec.imm == CC_ON)    en_q    <= 1'b1;
              if (dec.imm == CC_FLUSH) flush_q <= 1'b1;
              state <= S_FETCH;
            end
            default: state <= S_FETCH;
          endcase
        end
        S_MEM: begin
          if (dec.kind == K_SW) begin
            state <= S_FETCH;
          end else if (dmem_rvalid) begin
            res   <= dmem_rdata;
            state <= S_WB;
          end
        end
        S_WB:    state <= S_FETCH;
        S_HALT:  state <= S_HALT;
        default: state <= S_HALT;
      endcase
    end
  end

  assign imem_req    = (state == S_FETCH);
  assign imem_addr   = pc;
  assign dmem_req    = (state == S_MEM);
  assign dmem_we     = (state == S_MEM) && (dec.kind == K_SW);
  assign dmem_addr   = res;
  assign dmem_wdata  = opb;
  assign cache_en    = en_q;
  assign cache_flush = flush_q;
  assign halted      = (state == S_HALT);

endmodule

// File: rtl/mini_core_chk.sv
`timescale 1ns/1ps
module mini_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        imem_req,
  input logic [31:0] imem_addr,
  input logic        imem_rvalid,
  input logic        dmem_req,
  input logic        dmem_we,
  input logic [31:0] dmem_addr,
  input logic        dmem_rvalid,
  input logic        cache_en,
  input logic        cache_flush,
  input logic        halted,
  input logic [4:0]  rd_addr_a,
  input logic [31:0] rd_a
);
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req && !imem_rvalid |=> imem_req && $stable(imem_addr)); // R11
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_req && dmem_req)); // R11
  AST_FETCH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |-> imem_addr[1:0] == 2'b00); // R4
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req && !dmem_we && !dmem_rvalid |=> dmem_req && !dmem_we && $stable(dmem_addr)); // R6
  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req && dmem_we |=> !dmem_req); // R6
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cache_flush |=> !cache_flush); // R7
  AST_FLUSH_KEEP_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cache_flush |-> $stable(cache_en)); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !imem_req && !dmem_req); // R8
  AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_a == 5'd0 |-> rd_a == 32'd0); // R9
endmodule

bind mini_core mini_core_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_req   (imem_req),
  .imem_addr  (imem_addr),
  .imem_rvalid(imem_rvalid),
  .dmem_req   (dmem_req),
  .dmem_we    (dmem_we),
  .dmem_addr  (dmem_addr),
  .dmem_rvalid(dmem_rvalid),
  .cache_en   (cache_en),
  .cache_flush(cache_flush),
  .halted     (halted),
  .rd_addr_a  (rd_addr_a),
  .rd_a       (rd_a)
);

// File: tb/test_mini_core.sv
`timescale 1ns/1ps
module test_mini_core;

  function automatic logic [31:0] e_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] e_i(input logic [5:0] op, input int rt, input int rs, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] e_j(input logic [5:0] op, input int t);
    return {op, t[25:0]};
  endfunction

  localparam logic [5:0] ADD = 6'h20, SUB = 6'h22, SLT = 6'h2A;
  localparam logic [5:0] ADDI = 6'h08, BNE = 6'h05, J = 6'h02, JAL = 6'h03;
  localparam logic [5:0] LW = 6'h23, SW = 6'h2B, CCH = 6'h2F, HLT = 6'h3F;
  localparam logic [31:0] HALTW = {6'h3F, 26'd0};

  localparam int NPROG = 42;
  localparam logic [31:0] PROG [NPROG] = '{
    e_i(ADDI, 1, 0, 5),        //  0 R1=5
    e_i(ADDI, 2, 0, -3),       //  1 R2=-3
    e_r(ADD, 3, 1, 2),         //  2 R3=2
    e_r(SUB, 4, 2, 1),         //  3 R4=-8
    e_r(SLT, 5, 2, 1),         //  4 R5=1
    e_r(SLT, 6, 1, 2),         //  5 R6=0
    e_i(SW, 3, 0, 0),          //  6
    e_i(SW, 4, 0, 4),          //  7
    e_i(SW, 5, 0, 8),          //  8
    e_i(SW, 6, 0, 12),         //  9
    e_i(ADDI, 0, 0, 9),        // 10 write to R0
    e_i(SW, 0, 0, 16),         // 11
    e_i(LW, 8, 0, 100),        // 12
    e_i(SW, 8, 0, 20),         // 13
    e_i(BNE, 2, 1, 1),         // 14 taken -> 16
    e_i(ADDI, 9, 0, 77),       // 15 skipped
    e_i(SW, 9, 0, 24),         // 16
    e_i(BNE, 1, 1, 1),         // 17 not taken
    e_i(ADDI, 10, 0, 33),      // 18
    e_i(SW, 10, 0, 28),        // 19
    e_j(JAL, 23),              // 20 R7=84
    e_i(ADDI, 11, 0, 1),       // 21 skipped
    HALTW,                     // 22 skipped
    e_i(SW, 7, 0, 32),         // 23
    e_i(SW, 11, 0, 36),        // 24
    e_i(CCH, 0, 0, 1),         // 25 enable
    e_i(CCH, 0, 0, 3),         // 26 unknown code
    e_i(CCH, 0, 0, 2),         // 27 flush
    e_i(CCH, 0, 0, 0),         // 28 disable
    {6'h3E, 5'd1, 5'd1, 16'hFFFF},             // 29 undefined opcode
    {6'h00, 5'd1, 5'd1, 5'd1, 5'd0, 6'h3F},    // 30 unknown function
    e_j(J, 33),                // 31
    e_i(SW, 1, 0, 40),         // 32 skipped
    e_i(SW, 1, 0, 44),         // 33
    e_i(ADDI, 12, 0, 108),     // 34
    e_i(LW, 13, 12, -8),       // 35 address 100
    e_i(SW, 13, 0, 48),        // 36
    e_i(ADDI, 14, 14, 1),      // 37 loop body
    e_i(BNE, 1, 14, -2),       // 38 back to 37
    e_i(SW, 14, 0, 52),        // 39
    HALTW,                     // 40
    e_i(SW, 1, 0, 56)          // 41 never
  };

  localparam int NEXP = 13;
  localparam logic [31:0] EXP_ADDR [NEXP] = '{0, 4, 8, 12, 16, 20, 24, 28, 32, 36, 44, 48, 52};
  localparam logic [31:0] EXP_DATA [NEXP] = '{32'd2, 32'hFFFF_FFF8, 32'd1, 32'd0, 32'd0,
                                              32'h1234, 32'd0, 32'd33, 32'd84, 32'd0,
                                              32'd5, 32'h1234, 32'd5};

  function automatic string req_of(input int i);
    case (i)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4:       return "R9";
      5, 11:   return "R6";
      6, 7:    return "R4";
      8, 9:    return "R5";
      10:      return "R10";
      default: return "R4";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req, imem_rvalid;
  logic [31:0] imem_addr, imem_rdata;
  logic        dmem_req, dmem_we, dmem_rvalid;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        cache_en, cache_flush, halted;

  always #10 clk = ~clk;

  mini_core i_mini_core (
    .clk(clk), .rst_n(rst_n),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_rvalid(imem_rvalid), .imem_rdata(imem_rdata),
    .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_rvalid(dmem_rvalid), .dmem_rdata(dmem_rdata),
    .cache_en(cache_en), .cache_flush(cache_flush), .halted(halted)
  );

  // memory models
  logic [31:0] dmem [64];
  int          dwait;
  initial begin
    for (int i = 0; i < 64; i++) dmem[i] = 32'd0;
    dmem[25] = 32'h1234;
    imem_rvalid = 1'b0; imem_rdata = 32'd0;
    dmem_rvalid = 1'b0; dmem_rdata = 32'd0; dwait = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      imem_rvalid <= 1'b0;
      dmem_rvalid <= 1'b0;
      dwait       <= 0;
    end else begin
      imem_rvalid <= imem_req && !imem_rvalid;
      imem_rdata  <= (int'(imem_addr[7:2]) < NPROG) ? PROG[imem_addr[7:2]] : HALTW;
      dmem_rvalid <= 1'b0;
      if (dmem_req && dmem_we)
        dmem[dmem_addr[7:2]] <= dmem_wdata;
      if (dmem_req && !dmem_we && !dmem_rvalid) begin
        if (dwait == 2) begin
          dmem_rvalid <= 1'b1;
          dmem_rdata  <= dmem[dmem_addr[7:2]];
          dwait       <= 0;
        end else begin
          dwait <= dwait + 1;
        end
      end
    end
  end

  // monitors, sampled on the falling edge
  logic [31:0] st_addr [64];
  logic [31:0] st_data [64];
  int st_n = 0, rises = 0, falls = 0, flushes = 0, run = 0, maxrun = 0, flush_en = 0;
  logic en_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dmem_req && dmem_we && st_n < 64) begin
        st_addr[st_n] = dmem_addr;
        st_data[st_n] = dmem_wdata;
        st_n++;
      end
      if (cache_en && !en_prev) rises++;
      if (!cache_en && en_prev) falls++;
      if (cache_flush) begin
        flushes++;
        run++;
        if (run > maxrun) maxrun = run;
        if (cache_en) flush_en++;
      end else begin
        run = 0;
      end
      en_prev = cache_en;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  initial begin
    int cyc;
    int viol;
    repeat (3) @(negedge clk);
    chk("R1", "halted in reset", {31'd0, halted}, 32'd0);
    chk("R1", "cache_en in reset", {31'd0, cache_en}, 32'd0);
    chk("R1", "cache_flush in reset", {31'd0, cache_flush}, 32'd0);
    chk("R1", "dmem_req in reset", {31'd0, dmem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "first fetch request", {31'd0, imem_req}, 32'd1);
    chk("R1", "first fetch address", imem_addr, 32'd0);

    cyc = 0;
    while (!halted && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R8", "halted reached before watchdog", {31'd0, halted}, 32'd1);

    // stored results, one vector per expected store
    for (int i = 0; i < NEXP; i++) begin
      chk(req_of(i), $sformatf("store %0d address", i), st_addr[i], EXP_ADDR[i]);
      chk(req_of(i), $sformatf("store %0d data", i), st_data[i], EXP_DATA[i]);
    end
    chk("R5", "store count (skipped instructions)", st_n, NEXP);

    // halt is sticky and silent
    viol = 0;
    repeat (40) begin
      @(negedge clk);
      if (imem_req || dmem_req || !halted) viol++;
    end
    chk("R8", "requests or drop while halted", viol, 32'd0);
    chk("R8", "no store after halt", st_n, NEXP);

    // cache control
    chk("R7", "enable rises", rises, 32'd1);
    chk("R7", "enable falls", falls, 32'd1);
    chk("R7", "flush pulses (code 3 ignored)", flushes, 32'd1);
    chk("R7", "flush pulse width", maxrun, 32'd1);
    chk("R7", "flush while enabled", flush_en, 32'd1);
    chk("R7", "final enable", {31'd0, cache_en}, 32'd0);

    // reset after halt restarts at address 0
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "halted cleared by reset", {31'd0, halted}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "restart fetch address", imem_addr, 32'd0);
    chk("R11", "restart fetch request", {31'd0, imem_req}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule